// File: doc/BRIEF.md
# I2S Multi-Pair Audio Transmitter

This block is an I2S transmitter that drives the serial clocks itself. It serves up to four stereo lanes. Each lane has its own frame FIFO and its own serial data pin. All lanes share one bit clock and one word-select line. A small word-addressed register port loads samples and sets up the block. Software writes a left sample and then a right sample into a lane. The right-sample write stores the stereo pair in that lane's FIFO. At the start of every frame, each enabled lane takes one pair from its FIFO and shifts it out most-significant bit first.

The number of bit clocks per half-frame is set by its own encoded register. The resolution of each lane's samples is set by a second, separate encoded register. A narrower sample is padded with zero bits, and a wider one is cut to its upper bits. Each lane raises a threshold-based "running low" flag and a sticky overrun flag. Each flag has its own mask bit. The unmasked flags of all lanes are combined onto one interrupt line.

Address map: bits [7:4] of the address select a region. Region 0 holds the global registers, and region p+1 holds lane p. Bits [3:0] select the register inside the region.

Top module: `i2stx_top`

## Requirements
- R1: After reset, bclk, ws, every sd bit and irq are low. The global enables (region 0 offsets 0, 1 and 2) read 0. Each lane's mask register (offset 6) reads 0x30.
- R2: The serial clocks run only while three bits are all 1: the global enable (offset 0), the transmit enable (offset 1) and the clock enable (offset 2). If any of them is 0, bclk, ws and sd are held low.
- R3: The half-frame code (global offset 3) sets the half-frame width: 0x00 gives 16 bit clocks, 0x08 gives 24 and 0x10 gives 32. Any other code gives 16. One bclk period lasts 2*BCLK_DIV clock cycles.
- R4: ws is low during the left slot and high during the right slot. ws changes one bit clock before the MSB of each slot. Data changes after the falling edge of bclk, so a receiver samples it on the rising edge.
- R5: A lane's resolution code (offset 3) sets the sample width: 2 gives 16 bits, 4 gives 24 and 5 gives 32. Any other code gives 16. Samples go out MSB first. Bit clocks past the resolution carry zeros, and a sample wider than its slot sends only its top bits.
- R6: A write to offset 0 holds a left sample, and a write to offset 1 pushes the pair {left, right}. At each left-slot start, one pair is popped from each enabled lane (offset 2, bit 0). A disabled lane sends zeros and keeps its FIFO.
- R7: An enabled lane whose FIFO is empty at a frame start sends an all-zero frame.
- R8: Status bit 4 (offset 5) is 1 when the lane is enabled and its fill level is at or below the threshold register (offset 4). Status bits [15:8] hold the fill level.
- R9: A right-sample write into a full FIFO is dropped and sets status bit 5. Reading offset 7 clears status bit 5.
- R10: Mask bit 4 masks the low-fill flag and mask bit 5 masks the overrun flag. irq is the OR, over all lanes, of each unmasked flag.
- R11: Writing 1 in bit 0 of global offset 4 empties every lane's FIFO.
- R12: Global offset 5 is read-only and reads a code c such that the FIFO depth is 2^(1+c).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; enables read side effects |
| reg_addr | input | 8 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| bclk | output | 1 | Generated bit clock |
| ws | output | 1 | Word select, low for the left slot |
| sd | output | NPAIR | Serial data, one bit per lane |
| irq | output | 1 | Combined interrupt |

## Verification
The bench plays slot/resolution combinations where the sample is narrower than its slot, equal to it and wider than it. If the padding or truncation were wrong, the decoded words would show shifted or leaked low bits. The bench also checks where the word-select edge falls. An edge aligned with the MSB, rather than one bit clock before it, breaks the ws pattern check. Other corner cases are an empty FIFO at a frame boundary, where stale data would repeat, and a disabled lane, which must neither pop nor send. A write into a full FIFO must be dropped without corrupting the fill level, and the overrun flag must be cleared only by a read.

// File: rtl/i2stx_pkg.sv
`timescale 1ns/1ps
package i2stx_pkg;
  // Half-frame code to bit clocks per half-frame
  function automatic int unsigned hf_bits(input logic [7:0] code);
    case (code)
      8'h08:   return 24;
      8'h10:   return 32;
      default: return 16;
    endcase
  endfunction

  // Resolution code to significant sample bits
  function automatic int unsigned res_bits(input logic [3:0] code);
    case (code)
      4'h4:    return 24;
      4'h5:    return 32;
      default: return 16;
    endcase
  endfunction

  // Bit j (0 = first sent) of a slot carrying an r-bit sample
  function automatic logic slot_bit(input logic [31:0] s, input int unsigned j,
                                    input int unsigned r);
    logic [4:0] idx;
    if (j >= r) return 1'b0;
    idx = 5'(r - 1 - j);
    return s[idx];
  endfunction

  // Word select during bit k of a frame of 2*w bits (leads data by one bit)
  function automatic logic ws_at(input int unsigned k, input int unsigned w);
    return (k >= w - 1) && (k < 2 * w - 1);
  endfunction
endpackage

// File: rtl/i2stx_fifo.sv
`timescale 1ns/1ps
module i2stx_fifo #(
  parameter int DEPTH = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_l,
  input  logic                          wr_r,
  input  logic [31:0]                   wdata,
  input  logic                          pop,
  input  logic                          flush,
  input  logic                          ovr_clr,
  output logic [31:0]                   head_l,
  output logic [31:0]                   head_r,
  output logic [$clog2(DEPTH):0]        level,
  output logic                          ovr,
  output logic                          empty
);
  localparam int AW = $clog2(DEPTH);

  logic [31:0] mem_l [DEPTH];
  logic [31:0] mem_r [DEPTH];
  logic [31:0] hold;
  logic [AW-1:0] wp, rp;
  logic full, push_ok, drop, do_pop;

  assign full    = (level == (AW+1)'(DEPTH));
  assign empty   = (level == '0);
  assign push_ok = wr_r && !full && !flush;
  assign drop    = wr_r && full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign head_l  = mem_l[rp];
  assign head_r  = mem_r[rp];

  always_ff @(posedge clk) begin
    if (push_ok) begin
      mem_l[wp] <= hold;
      mem_r[wp] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; level <= '0; ovr <= 1'b0; hold <= '0;
    end else begin
      if (wr_l) hold <= wdata;
      if (flush) begin
        wp <= '0; rp <= '0; level <= '0;
      end else begin
        if (push_ok) wp <= wp + 1'b1;
        if (do_pop)  rp <= rp + 1'b1;
        level <= level + (AW+1)'(push_ok) - (AW+1)'(do_pop);
      end
      if (drop)         ovr <= 1'b1;
      else if (ovr_clr) ovr <= 1'b0;
    end
  end

  // R9
  drop_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && !pop) |=> (ovr && $stable(level)));
  // R11
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (level == '0));
  // R6
  level_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= (AW+1)'(DEPTH));
endmodule

// File: rtl/i2stx_clkgen.sv
`timescale 1ns/1ps
module i2stx_clkgen #(
  parameter int DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active,
  input  logic [5:0] hw,
  output logic       bclk,
  output logic       ws,
  output logic       bit_ev,
  output logic       frame_ev,
  output logic [5:0] nk
);
  import i2stx_pkg::*;
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic          running;
  logic [CW-1:0] dcnt;
  logic [5:0]    k;
  logic          start, fall, dtop;
  logic [6:0]    last;

  assign last     = {hw, 1'b0} - 7'd1;
  assign dtop     = (dcnt == CW'(DIV - 1));
  assign start    = active && !running;
  assign fall     = active && running && bclk && dtop;
  assign bit_ev   = start || fall;
  assign nk       = (start || ({1'b0, k} >= last)) ? 6'd0 : k + 6'd1;
  assign frame_ev = bit_ev && (nk == 6'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0; dcnt <= '0; bclk <= 1'b0; k <= '0; ws <= 1'b0;
    end else if (!active) begin
      running <= 1'b0; dcnt <= '0; bclk <= 1'b0; k <= '0; ws <= 1'b0;
    end else begin
      running <= 1'b1;
      if (start) begin
        dcnt <= '0;
        bclk <= 1'b0;
      end else begin
        dcnt <= dtop ? '0 : dcnt + 1'b1;
        if (dtop) bclk <= ~bclk;
      end
      if (bit_ev) begin
        k  <= nk;
        ws <= ws_at(int'(nk), int'(hw));
      end
    end
  end

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (!bclk && !ws));
  // R3
  bclk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && running && !dtop) |=> (!active || $stable(bclk)));
  // R4
  ws_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ev |=> !ws);
endmodule

// File: rtl/i2stx_lane.sv
`timescale 1ns/1ps
module i2stx_lane (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        active,
  input  logic        pen,
  input  logic        bit_ev,
  input  logic        frame_ev,
  input  logic [5:0]  nk,
  input  logic [5:0]  hw,
  input  logic [3:0]  res_code,
  input  logic [31:0] head_l,
  input  logic [31:0] head_r,
  input  logic        empty,
  output logic        pop,
  output logic        sd
);
  import i2stx_pkg::*;

  logic [31:0] sh_l, sh_r, cur_l, cur_r;
  logic        take, nbit;
  int unsigned rbits;

  assign take  = frame_ev && pen && !empty;
  assign pop   = take;
  assign cur_l = frame_ev ? (take ? head_l : 32'd0) : sh_l;
  assign cur_r = frame_ev ? (take ? head_r : 32'd0) : sh_r;

  always_comb begin
    rbits = res_bits(res_code);
    if (nk < hw) nbit = slot_bit(cur_l, int'(nk), rbits);
    else         nbit = slot_bit(cur_r, int'(nk - hw), rbits);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_l <= '0; sh_r <= '0; sd <= 1'b0;
    end else if (!active) begin
      sd <= 1'b0;
    end else begin
      if (frame_ev) begin
        sh_l <= cur_l;
        sh_r <= cur_r;
      end
      if (bit_ev) sd <= nbit;
    end
  end

  // R2
  idle_sd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !sd);
  // R7
  underflow_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && frame_ev && (empty || !pen)) |=> !sd);
endmodule

// File: rtl/i2stx_top.sv
`timescale 1ns/1ps
module i2stx_top #(
  parameter int NPAIR   = 4,
  parameter int DEPTH   = 8,
  parameter int BCLK_DIV = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [7:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             bclk,
  output logic             ws,
  output logic [NPAIR-1:0] sd,
  output logic             irq
);
  import i2stx_pkg::*;
  localparam int AW = $clog2(DEPTH);

  logic [3:0] region, off;
  logic       gen_en, tx_en, clk_en, active, flush;
  logic [7:0] hf_code;
  logic [5:0] hw, nk;
  logic       bit_ev, frame_ev;

  logic [NPAIR-1:0]         pen, empf, ovr, pempty, pop;
  logic [NPAIR-1:0][3:0]    res;
  logic [NPAIR-1:0][AW:0]   thr, lvl;
  logic [NPAIR-1:0][1:0]    mask;
  logic                     all_masked;

  assign region = reg_addr[7:4];
  assign off    = reg_addr[3:0];
  assign active = gen_en && tx_en && clk_en;
  assign hw     = 6'(hf_bits(hf_code));
  assign flush  = reg_wr && (region == 4'd0) && (off == 4'd4) && reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_en <= 1'b0; tx_en <= 1'b0; clk_en <= 1'b0; hf_code <= 8'h00;
    end else if (reg_wr && region == 4'd0) begin
      case (off)
        4'd0: gen_en  <= reg_wdata[0];
        4'd1: tx_en   <= reg_wdata[0];
        4'd2: clk_en  <= reg_wdata[0];
        4'd3: hf_code <= reg_wdata[7:0];
        default: ;
      endcase
    end
  end

  i2stx_clkgen #(.DIV(BCLK_DIV)) u_clk (
    .clk(clk), .rst_n(rst_n), .active(active), .hw(hw),
    .bclk(bclk), .ws(ws), .bit_ev(bit_ev), .frame_ev(frame_ev), .nk(nk)
  );

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    logic          hit;
    logic          pen_q;
    logic [3:0]    res_q;
    logic [AW:0]   thr_q;
    logic [1:0]    mask_q;
    logic [31:0]   hl, hr;

    assign hit = (region == 4'(p + 1));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pen_q <= 1'b0; res_q <= 4'h2;
        thr_q <= (AW+1)'(DEPTH / 2 - 1); mask_q <= 2'b11;
      end else if (reg_wr && hit) begin
        case (off)
          4'd2: pen_q  <= reg_wdata[0];
          4'd3: res_q  <= reg_wdata[3:0];
          4'd4: thr_q  <= reg_wdata[AW:0];
          4'd6: mask_q <= reg_wdata[5:4];
          default: ;
        endcase
      end
    end

    assign pen[p]  = pen_q;
    assign res[p]  = res_q;
    assign thr[p]  = thr_q;
    assign mask[p] = mask_q;
    assign empf[p] = pen_q && (lvl[p] <= thr_q);

    i2stx_fifo #(.DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n),
      .wr_l(reg_wr && hit && off == 4'd0),
      .wr_r(reg_wr && hit && off == 4'd1),
      .wdata(reg_wdata), .pop(pop[p]), .flush(flush),
      .ovr_clr(reg_rd && hit && off == 4'd7),
      .head_l(hl), .head_r(hr), .level(lvl[p]), .ovr(ovr[p]), .empty(pempty[p])
    );

    i2stx_lane u_lane (
      .clk(clk), .rst_n(rst_n), .active(active), .pen(pen_q),
      .bit_ev(bit_ev), .frame_ev(frame_ev), .nk(nk), .hw(hw), .res_code(res_q),
      .head_l(hl), .head_r(hr), .empty(pempty[p]), .pop(pop[p]), .sd(sd[p])
    );
  end

  always_comb begin
    irq = 1'b0;
    all_masked = 1'b1;
    for (int p = 0; p < NPAIR; p++) begin
      irq = irq | (empf[p] & ~mask[p][0]) | (ovr[p] & ~mask[p][1]);
      all_masked = all_masked & (&mask[p]);
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (region == 4'd0) begin
      case (off)
        4'd0: reg_rdata[0]   = gen_en;
        4'd1: reg_rdata[0]   = tx_en;
        4'd2: reg_rdata[0]   = clk_en;
        4'd3: reg_rdata[7:0] = hf_code;
        4'd5: reg_rdata[3:0] = 4'(AW - 1);
        default: ;
      endcase
    end
    for (int p = 0; p < NPAIR; p++) begin
      if (region == 4'(p + 1)) begin
        case (off)
          4'd2: reg_rdata[0]    = pen[p];
          4'd3: reg_rdata[3:0]  = res[p];
          4'd4: reg_rdata[AW:0] = thr[p];
          4'd5: begin
            reg_rdata[4]        = empf[p];
            reg_rdata[5]        = ovr[p];
            reg_rdata[8 +: AW+1] = lvl[p];
          end
          4'd6: reg_rdata[5:4]  = mask[p];
          default: ;
        endcase
      end
    end
  end

  // R10
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    all_masked |-> !irq);
  // R6
  pop_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop != '0) |-> (frame_ev && active));
endmodule

// File: tb/sim_i2stx_top.sv
`timescale 1ns/1ps
module sim_i2stx_top;
  localparam int NPAIR = 4;
  localparam int DEPTH = 8;
  localparam int DIV   = 2;
  localparam int AW    = $clog2(DEPTH);

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic bclk, ws, irq;
  logic [NPAIR-1:0] sd;

  int checks = 0, fails = 0;

  i2stx_top #(.NPAIR(NPAIR), .DEPTH(DEPTH), .BCLK_DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .bclk(bclk), .ws(ws), .sd(sd), .irq(irq)
  );

  always #10 clk = ~clk;

  // {half-frame code, resolution code, left, right}
  localparam logic [75:0] VEC [6] = '{
    {8'h00, 4'h2, 32'h0000A5C3, 32'h00001234},
    {8'h08, 4'h4, 32'h00ABCDEF, 32'h00123456},
    {8'h10, 4'h5, 32'hDEADBEEF, 32'h13579BDF},
    {8'h10, 4'h2, 32'h0000F00F, 32'h00008001},
    {8'h00, 4'h5, 32'h89ABCDEF, 32'h76543210},
    {8'h08, 4'h2, 32'h0000FFFF, 32'h00000001}
  };

  logic [NPAIR-1:0] cap_sd [128];
  logic             cap_ws [128];

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic capture(input int n);
    logic prev = bclk;
    int i = 0;
    while (i < n) begin
      @(negedge clk);
      if (bclk && !prev) begin
        cap_sd[i] = sd; cap_ws[i] = ws; i++;
      end
      prev = bclk;
    end
  endtask

  function automatic int hf_w(input logic [7:0] c);
    return (c == 8'h08) ? 24 : (c == 8'h10) ? 32 : 16;
  endfunction
  function automatic int rs_w(input logic [3:0] c);
    return (c == 4'h4) ? 24 : (c == 4'h5) ? 32 : 16;
  endfunction
  function automatic logic [31:0] exp_word(input logic [31:0] s, input int r, input int w);
    logic [31:0] x = '0;
    for (int j = 0; j < w; j++) x = {x[30:0], (j < r) ? s[r-1-j] : 1'b0};
    return x;
  endfunction
  function automatic logic [31:0] got_word(input int from, input int w, input int lane);
    logic [31:0] x = '0;
    for (int j = 0; j < w; j++) x = {x[30:0], cap_sd[from + j][lane]};
    return x;
  endfunction

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int w, r, seen, cnt;
    bit ok;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(!bclk && !ws && sd == '0 && !irq, "R1 outputs low", {bclk, ws, irq}, 0);
    rd(8'h16, d); check(d == 32'h30, "R1 mask reset", d, 32'h30);
    rd(8'h00, d); check(d == 0, "R1 global enable reset", d, 0);

    // R12 depth code
    rd(8'h05, d); check((1 << (1 + d)) == DEPTH, "R12 depth code", d, AW - 1);

    // R2 no clock unless all three enables set
    wr(8'h00, 1); wr(8'h12, 1); wr(8'h01, 1);
    seen = 0;
    repeat (40) begin @(negedge clk); if (bclk) seen++; end
    check(seen == 0, "R2 clock enable off keeps bclk low", seen, 0);
    wr(8'h01, 0); wr(8'h02, 1);

    // R3 R4 R5 vector table
    foreach (VEC[v]) begin
      w = hf_w(VEC[v][75:68]); r = rs_w(VEC[v][67:64]);
      wr(8'h01, 0);
      wr(8'h03, {24'd0, VEC[v][75:68]});
      wr(8'h13, {28'd0, VEC[v][67:64]});
      wr(8'h04, 1);
      wr(8'h10, VEC[v][63:32]);
      wr(8'h11, VEC[v][31:0]);
      wr(8'h01, 1);
      capture(2 * w);
      d = got_word(0, w, 0);
      check(d == exp_word(VEC[v][63:32], r, w), "R5 left slot", d, exp_word(VEC[v][63:32], r, w));
      d = got_word(w, w, 0);
      check(d == exp_word(VEC[v][31:0], r, w), "R5 right slot", d, exp_word(VEC[v][31:0], r, w));
      ok = 1;
      for (int k = 0; k < 2 * w; k++)
        if (cap_ws[k] != ((k >= w - 1) && (k < 2 * w - 1))) ok = 0;
      check(ok, "R3 R4 ws pattern", v, w);
    end
    wr(8'h01, 0);

    // R3 bclk period
    wr(8'h01, 1);
    @(negedge clk); while (!bclk) @(negedge clk);
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (bclk);
    do begin @(negedge clk); cnt++; end while (!bclk);
    check(cnt == 2 * DIV, "R3 bclk period", cnt, 2 * DIV);
    wr(8'h01, 0);

    // R7 underflow zeros, R6 disabled lane keeps FIFO
    wr(8'h03, 0); wr(8'h13, 2); wr(8'h04, 1);
    wr(8'h10, 32'hFFFF); wr(8'h11, 32'hFFFF);
    wr(8'h22, 0); wr(8'h20, 32'hAAAA); wr(8'h21, 32'h5555);
    wr(8'h01, 1);
    capture(64);
    d = got_word(0, 16, 0);
    check(d == 32'hFFFF, "R6 first frame sent", d, 32'hFFFF);
    d = got_word(32, 16, 0) | got_word(48, 16, 0);
    check(d == 0, "R7 underflow frame zero", d, 0);
    d = got_word(0, 16, 1) | got_word(16, 16, 1);
    check(d == 0, "R6 disabled lane silent", d, 0);
    rd(8'h25, d); check(d[15:8] == 1, "R6 disabled lane keeps frame", d[15:8], 1);
    rd(8'h15, d); check(d[15:8] == 0, "R6 enabled lane popped", d[15:8], 0);

    // R2 stop on transmit enable clear
    wr(8'h01, 0);
    seen = 0;
    repeat (20) begin @(negedge clk); if (bclk || ws || sd != 0) seen++; end
    check(seen == 0, "R2 stopped outputs low", seen, 0);

    // R8 threshold flag
    wr(8'h04, 1); wr(8'h14, 3);
    for (int i = 0; i < 3; i++) begin wr(8'h10, i); wr(8'h11, i); end
    rd(8'h15, d); check(d[4] == 1, "R8 low flag at threshold", d[4], 1);
    wr(8'h10, 3); wr(8'h11, 3);
    rd(8'h15, d); check(d[4] == 0, "R8 low flag above threshold", d[4], 0);

    // R9 overrun
    for (int i = 0; i < 4; i++) begin wr(8'h10, 9); wr(8'h11, 9); end
    rd(8'h15, d); check(d[5] == 0 && d[15:8] == DEPTH, "R9 full no overrun", d, DEPTH << 8);
    wr(8'h10, 7); wr(8'h11, 7);
    rd(8'h15, d); check(d[5] == 1 && d[15:8] == DEPTH, "R9 overrun set, write dropped", d, (DEPTH << 8) | 32'h20);
    @(negedge clk); check(!irq, "R10 masked overrun no irq", irq, 0);
    wr(8'h16, 32'h10);
    @(negedge clk); check(irq, "R10 unmasked overrun irq", irq, 1);
    rd(8'h17, d);
    rd(8'h15, d); check(d[5] == 0, "R9 read clears overrun", d[5], 0);
    check(!irq, "R10 irq drops after clear", irq, 0);

    // R11 flush
    wr(8'h04, 1);
    rd(8'h15, d); check(d[15:8] == 0, "R11 flush empties", d[15:8], 0);
    wr(8'h16, 32'h20);
    @(negedge clk); check(irq, "R10 R8 unmasked low flag irq", irq, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule